// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Unit

This block is a parameterised bank of general-purpose pins for a socket controller. Every pin can be an output or an input. Inputs pass through a synchroniser and are then watched for level changes. A rising change and a falling change each latch a separate sticky status bit. Each kind of change has its own enable word. The single interrupt line is raised while any enabled status bit is pending. Software clears a status bit by writing a one to it.

Two pins have a fixed meaning. One pin carries the card-ready signal and one carries the card-detect signal. A service code tells the host which of the two events to handle first, and card-ready always comes first. A second detect pin joins the first in a socket-empty flag. Both detect pins are active low. The host reaches the registers over a 16-bit word bus that swaps the two bytes: the host's high byte lands in the register's low byte, and the same holds for reads.

Top module: `edge_gpio_unit`

## Requirements
- R1: After reset, every register reads zero and all pins are inputs (`pin_oe` = 0). `irq` is low and `svc_code` is 00.
- R2: `pin_oe` equals the direction register, where 1 means output. `pin_out` carries the output-data bit where the direction bit is 1 and 0 elsewhere.
- R3: The input-data register reads `pin_in` through a two-stage synchroniser, so a change is visible after two clock edges. Writes to it have no effect.
- R4: A 0-to-1 change of a synchronised input sets that pin's rise-status bit, and a 1-to-0 change sets its fall-status bit. This happens whatever the enables hold, and the bit stays set until it is cleared.
- R5: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If a new change and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: `irq` is high exactly when (rise-status AND rise-enable) OR (fall-status AND fall-enable) is non-zero. It follows status and enable changes in the same cycle.
- R8: `svc_code` is 10 when the fall-status bit of the card-ready pin (pin 0) is pending and enabled. Otherwise it is 01 when the fall-status bit of the card-detect pin (pin 9) is pending and enabled. Otherwise it is 00. Card-ready wins when both are pending.
- R9: Registers sit at word offsets 0 direction, 1 output data, 2 input data, 3 rise enable, 4 fall enable, 5 rise status, 6 fall status. Offset 7 reads zero. Reads are combinational. Host data bits 15:8 map to register bits 7:0 and host bits 7:0 map to register bits 15:8, on both writes and reads.
- R10: `socket_empty` is high when either synchronised detect input (pin 9 or pin 10) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data, host byte order |
| bus_rdata | output | 16 | Read data, host byte order |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 1 | Interrupt request |
| svc_code | output | 2 | Service code: 10 ready, 01 detect, 00 none |
| socket_empty | output | 1 | Socket has no card |

## Verification
A register write takes effect at the clock edge that samples it, so `pin_oe`, `pin_out`, `irq` and `svc_code` are checked at the falling edge that follows. A pin change is seen by the input register two edges later and sets a status bit on the third edge. The bench therefore holds the pins steady for four cycles before it reads or checks anything that depends on them. The same-cycle collision between a change and a clearing write is timed directly: the clearing write is placed at the third edge after the pin change.

// File: rtl/gpio_unit_pkg.sv
package gpio_unit_pkg;
   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] OFS_DIR   = 3'd0;
   localparam logic [REG_AW-1:0] OFS_DOUT  = 3'd1;
   localparam logic [REG_AW-1:0] OFS_DIN   = 3'd2;
   localparam logic [REG_AW-1:0] OFS_REN   = 3'd3;
   localparam logic [REG_AW-1:0] OFS_FEN   = 3'd4;
   localparam logic [REG_AW-1:0] OFS_RSTAT = 3'd5;
   localparam logic [REG_AW-1:0] OFS_FSTAT = 3'd6;

   typedef enum logic [1:0] {
      SVC_NONE   = 2'b00,
      SVC_DETECT = 2'b01,
      SVC_READY  = 2'b10
   } svc_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_track.sv
module gpio_edge_track #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] rise_clr,
   input  logic [W-1:0] fall_clr,
   output logic [W-1:0] rise_evt,
   output logic [W-1:0] fall_evt,
   output logic [W-1:0] rise_stat,
   output logic [W-1:0] fall_stat
);
   logic [W-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= level;
   end

   assign rise_evt = level & ~level_q;
   assign fall_evt = ~level & level_q;

   // an incoming change outranks a clearing write on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_stat <= '0;
         fall_stat <= '0;
      end else begin
         rise_stat <= (rise_stat & ~rise_clr) | rise_evt;
         fall_stat <= (fall_stat & ~fall_clr) | fall_evt;
      end
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_unit_pkg::*;
#(
   parameter int W     = 16,
   parameter int BUS_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [W-1:0]      din,
   input  logic [W-1:0]      rise_stat,
   input  logic [W-1:0]      fall_stat,
   output logic [W-1:0]      dir,
   output logic [W-1:0]      dout,
   output logic [W-1:0]      rise_en,
   output logic [W-1:0]      fall_en,
   output logic [W-1:0]      rise_clr,
   output logic [W-1:0]      fall_clr
);
   localparam int NBYTES = BUS_W / 8;

   logic [BUS_W-1:0] wr_word;
   logic [BUS_W-1:0] rd_word;
   logic             wr_hit;

   // host and register byte orders are mirror images
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign wr_word[b*8 +: 8]   = bus_wdata[(NBYTES-1-b)*8 +: 8];
      assign bus_rdata[b*8 +: 8] = rd_word[(NBYTES-1-b)*8 +: 8];
   end

   assign wr_hit = bus_sel & bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir     <= '0;
         dout    <= '0;
         rise_en <= '0;
         fall_en <= '0;
      end else if (wr_hit) begin
         case (bus_addr)
            OFS_DIR:  dir     <= wr_word[W-1:0];
            OFS_DOUT: dout    <= wr_word[W-1:0];
            OFS_REN:  rise_en <= wr_word[W-1:0];
            OFS_FEN:  fall_en <= wr_word[W-1:0];
            default: ;
         endcase
      end
   end

   assign rise_clr = (wr_hit && bus_addr == OFS_RSTAT) ? wr_word[W-1:0] : '0;
   assign fall_clr = (wr_hit && bus_addr == OFS_FSTAT) ? wr_word[W-1:0] : '0;

   always_comb begin
      case (bus_addr)
         OFS_DIR:   rd_word = BUS_W'(dir);
         OFS_DOUT:  rd_word = BUS_W'(dout);
         OFS_DIN:   rd_word = BUS_W'(din);
         OFS_REN:   rd_word = BUS_W'(rise_en);
         OFS_FEN:   rd_word = BUS_W'(fall_en);
         OFS_RSTAT: rd_word = BUS_W'(rise_stat);
         OFS_FSTAT: rd_word = BUS_W'(fall_stat);
         default:   rd_word = '0;
      endcase
   end
endmodule

// File: rtl/gpio_service.sv
module gpio_service
   import gpio_unit_pkg::*;
#(
   parameter int W       = 16,
   parameter int RDY_PIN = 0,
   parameter int DET_PIN = 9,
   parameter int DET2_PIN = 10
) (
   input  logic [W-1:0] rise_stat,
   input  logic [W-1:0] fall_stat,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] din,
   output logic         irq,
   output logic [1:0]   svc_code,
   output logic         socket_empty
);
   logic [W-1:0] live;
   logic         rdy_pend;
   logic         det_pend;
   svc_e         svc;

   assign live     = (rise_stat & rise_en) | (fall_stat & fall_en);
   assign irq      = |live;
   assign rdy_pend = fall_stat[RDY_PIN] & fall_en[RDY_PIN];
   assign det_pend = fall_stat[DET_PIN] & fall_en[DET_PIN];

   always_comb begin
      if (rdy_pend)      svc = SVC_READY;
      else if (det_pend) svc = SVC_DETECT;
      else               svc = SVC_NONE;
   end

   assign svc_code     = svc;
   assign socket_empty = din[DET_PIN] | din[DET2_PIN];
endmodule

// File: rtl/edge_gpio_unit.sv
module edge_gpio_unit
   import gpio_unit_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int BUS_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RDY_PIN     = 0,
   parameter int DET_PIN     = 9,
   parameter int DET2_PIN    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq,
   output logic [1:0]        svc_code,
   output logic              socket_empty
);
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
      $fatal(1, "NPINS must lie in 1..BUS_W");
   end
   if (BUS_W % 8 != 0) begin : g_bad_busw
      $fatal(1, "BUS_W must be whole bytes");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be at least 2");
   end
   if (RDY_PIN >= NPINS || DET_PIN >= NPINS || DET2_PIN >= NPINS) begin : g_bad_pin
      $fatal(1, "special pin index out of range");
   end

   logic [NPINS-1:0] din, dir, dout, rise_en, fall_en;
   logic [NPINS-1:0] rise_stat, fall_stat, rise_evt, fall_evt;
   logic [NPINS-1:0] rise_clr, fall_clr;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din)
   );

   gpio_edge_track #(.W(NPINS)) u_track (
      .clk(clk), .rst_n(rst_n), .level(din),
      .rise_clr(rise_clr), .fall_clr(fall_clr),
      .rise_evt(rise_evt), .fall_evt(fall_evt),
      .rise_stat(rise_stat), .fall_stat(fall_stat)
   );

   gpio_regfile #(.W(NPINS), .BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .din(din), .rise_stat(rise_stat), .fall_stat(fall_stat),
      .dir(dir), .dout(dout), .rise_en(rise_en), .fall_en(fall_en),
      .rise_clr(rise_clr), .fall_clr(fall_clr)
   );

   gpio_service #(.W(NPINS), .RDY_PIN(RDY_PIN), .DET_PIN(DET_PIN),
                  .DET2_PIN(DET2_PIN)) u_svc (
      .rise_stat(rise_stat), .fall_stat(fall_stat),
      .rise_en(rise_en), .fall_en(fall_en), .din(din),
      .irq(irq), .svc_code(svc_code), .socket_empty(socket_empty)
   );

   assign pin_oe  = dir;
   assign pin_out = dout & dir;
endmodule

// File: rtl/gpio_unit_chk.sv
module gpio_unit_chk #(
   parameter int NPINS   = 16,
   parameter int RDY_PIN = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] rise_stat,
   input logic [NPINS-1:0] fall_stat,
   input logic [NPINS-1:0] fall_en,
   input logic [NPINS-1:0] rise_evt,
   input logic [NPINS-1:0] fall_evt,
   input logic [NPINS-1:0] rise_clr,
   input logic             irq,
   input logic [1:0]       svc_code
);
   assert_out_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   assert_rise_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_stat & ~rise_clr) != '0 |=>
         (rise_stat & $past(rise_stat & ~rise_clr)) == $past(rise_stat & ~rise_clr));

   assert_rise_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_clr & ~rise_evt) != '0 |=>
         (rise_stat & $past(rise_clr & ~rise_evt)) == '0);

   assert_rise_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_evt != '0 |=> (rise_stat & $past(rise_evt)) == $past(rise_evt));

   assert_fall_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt != '0 |=> (fall_stat & $past(fall_evt)) == $past(fall_evt));

   assert_quiet_no_svc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> svc_code == 2'b00);

   assert_ready_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_stat[RDY_PIN] && fall_en[RDY_PIN]) |-> (irq && svc_code == 2'b10));
endmodule

bind edge_gpio_unit gpio_unit_chk #(.NPINS(NPINS), .RDY_PIN(RDY_PIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe),
   .rise_stat(rise_stat), .fall_stat(fall_stat), .fall_en(fall_en),
   .rise_evt(rise_evt), .fall_evt(fall_evt), .rise_clr(rise_clr),
   .irq(irq), .svc_code(svc_code)
);

// File: tb/tb_edge_gpio_unit.sv
module tb_edge_gpio_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic [15:0] pin_in = '0, pin_out, pin_oe;
   logic        irq, socket_empty;
   logic [1:0]  svc_code;

   int checks = 0, fails = 0;

   // bench-side expected state
   logic [15:0] m_dir = '0, m_dout = '0, m_ren = '0, m_fen = '0;
   logic [15:0] m_rst = '0, m_fst = '0, m_pins = '0;

   always #4 clk = ~clk;

   edge_gpio_unit dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
      .svc_code(svc_code), .socket_empty(socket_empty)
   );

   function automatic logic [15:0] sw(logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction

   function automatic logic [1:0] exp_svc();
      if (m_fst[0] & m_fen[0]) return 2'b10;
      if (m_fst[9] & m_fen[9]) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [15:0] exp_reg(int a);
      case (a)
         0: return m_dir;  1: return m_dout; 2: return m_pins;
         3: return m_ren;  4: return m_fen;  5: return m_rst;
         6: return m_fst;  default: return 16'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [2:0] a, logic [15:0] logical);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = sw(logical);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      case (a)
         3'd0: m_dir  = logical;
         3'd1: m_dout = logical;
         3'd3: m_ren  = logical;
         3'd4: m_fen  = logical;
         3'd5: m_rst  = m_rst & ~logical;
         3'd6: m_fst  = m_fst & ~logical;
         default: ;
      endcase
   endtask

   task automatic bus_read(logic [2:0] a, output logic [15:0] logical);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      logical = sw(bus_rdata);
      bus_sel = 1'b0;
   endtask

   task automatic set_pins(logic [15:0] v);
      @(negedge clk);
      pin_in = v;
      m_rst = m_rst | (v & ~m_pins);
      m_fst = m_fst | (~v & m_pins);
      m_pins = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_all(string tag);
      logic [15:0] r;
      for (int a = 0; a < 8; a++) begin
         bus_read(a[2:0], r);
         case (a)
            0: chk({"R2 R9 dir ", tag}, r, exp_reg(a));
            2: chk({"R3 din ", tag}, r, exp_reg(a));
            5, 6: chk({"R4 R5 status ", tag}, r, exp_reg(a));
            7: chk({"R9 unmapped ", tag}, r, 16'h0);
            default: chk({"R9 reg ", tag}, r, exp_reg(a));
         endcase
      end
      chk({"R2 oe ", tag}, pin_oe, m_dir);
      chk({"R2 out ", tag}, pin_out, m_dout & m_dir);
      chk({"R7 irq ", tag}, {15'd0, irq},
          {15'd0, |((m_rst & m_ren) | (m_fst & m_fen))});
      chk({"R8 svc ", tag}, {14'd0, svc_code}, {14'd0, exp_svc()});
      chk({"R10 empty ", tag}, {15'd0, socket_empty}, {15'd0, m_pins[9] | m_pins[10]});
   endtask

   initial begin
      #(8 * 150000);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [15:0] r;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 oe", pin_oe, 16'h0);
      chk("R1 irq", {15'd0, irq}, 16'h0);
      chk("R1 svc", {14'd0, svc_code}, 16'h0);
      check_all("reset R1");

      // R9 raw byte order: host 0x12AB becomes register 0xAB12
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h12AB;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; m_dir = 16'hAB12;
      chk("R9 swap on write", pin_oe, 16'hAB12);
      @(negedge clk);
      bus_sel = 1'b1; bus_addr = 3'd0; #1;
      chk("R9 swap on read", bus_rdata, 16'h12AB);
      bus_sel = 1'b0;

      // R3 write to input register ignored
      bus_write(3'd2, 16'hFFFF);
      check_all("din write R3");

      // R4 edges set status without enables; R5 clear
      set_pins(16'h00F0);
      check_all("rise R4");
      set_pins(16'h0030);
      check_all("fall R4");
      bus_write(3'd5, 16'h0010);
      check_all("partial clear R5");

      // R6 event coincides with clearing write at third edge
      set_pins(16'h0038);
      set_pins(16'h0030);
      @(negedge clk);
      pin_in = 16'h0038;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = sw(16'h0008);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      m_pins = 16'h0038;
      repeat (2) @(negedge clk);
      bus_read(3'd5, r);
      chk("R6 event beats clear", r & 16'h0008, 16'h0008);
      check_all("collision R6");

      // R8 priority: detect alone, then both pending
      bus_write(3'd4, 16'h0201);
      set_pins(16'h0238);
      set_pins(16'h0038);
      check_all("detect only R8");
      set_pins(16'h0039);
      set_pins(16'h0038);
      check_all("ready wins R8");
      bus_write(3'd6, 16'h0001);
      check_all("ready cleared R8");
      set_pins(16'h0438);
      check_all("det2 empty R10");

      // constrained random mix
      for (int i = 0; i < 250; i++) begin
         int op = $urandom_range(0, 3);
         if (op == 0) begin
            set_pins(16'($urandom()));
         end else begin
            logic [2:0] a = 3'($urandom_range(0, 7));
            bus_write(a, 16'($urandom()));
         end
         if (i % 5 == 0) check_all("random");
         else begin
            chk("R7 irq random", {15'd0, irq},
                {15'd0, |((m_rst & m_ren) | (m_fst & m_fen))});
            chk("R8 svc random", {14'd0, svc_code}, {14'd0, exp_svc()});
         end
      end
      check_all("final");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule